// File: doc/BRIEF.md
# Descriptor-Driven Data Transfer Engine

This block moves single data words between memory locations without a processor in the loop. It holds no per-channel state of its own. Every channel is a four-word descriptor kept in ordinary memory, so the number of channels is bounded only by memory size. An activation pulse supplies the base address of a descriptor. The engine reads that descriptor and moves one word from the source address to the destination address. It then writes the updated source, destination and count back in place.

A descriptor may link to the descriptor stored directly after it, so that one activation runs several moves. The link can also be made conditional on the count having just reached zero, which lets a channel reload its own settings. A 16-bit module-stop register sits beside the engine. One bit of that register keeps the engine parked and leaves activations pending. That bit cannot be set while a transfer is running.

Top module: `dxfer_engine`

## Requirements
- R1: After reset, `reg_rdata` reads 0x3FFF, `busy` is low and `mem_req_valid` is low.
- R2: While `stby_hw` is high at a clock edge, the stop register reloads 0x3FFF. This takes priority over a write in the same cycle.
- R3: A write through `reg_we` while idle stores all 16 bits, visible on `reg_rdata` after one edge. While `busy` is high, a write leaves bit 14 at its previous value and stores the other bits.
- R4: While bit 14 of the stop register is 1, an activation stays pending, `busy` stays low and no memory request is issued. Once bit 14 is cleared, the pending activation is served.
- R5: An activation at base B issues nine bus cycles in this order: read B (control), read B+1 (source), read B+2 (destination), read B+3 (count), read the source address, write the fetched word to the destination address, write B+1, write B+2, write B+3.
- R6: Control word bit 0 set makes the source advance by 1 per move (otherwise it stays fixed), and bit 1 does the same for the destination. The count written back is the fetched count minus 1, modulo 2^16.
- R7: When control bit 2 is 1 and bit 3 is 0, the engine continues with the descriptor at B+4 in the same activation, with no new request.
- R8: When control bits 2 and 3 are both 1, the engine continues at B+4 only if the updated count is 0. Otherwise the activation ends.
- R9: A memory request holds valid, address and write flag stable until `mem_req_ready`. At most one access is outstanding. A bus cycle ends with `mem_rsp_valid`.
- R10: `busy` goes high on the second clock edge after `act_req` is sampled while the engine is idle and not stopped. It stays high until the response of the final write-back of the activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_hw | input | 1 | Hardware standby; reloads the stop register |
| act_req | input | 1 | Activation pulse |
| act_base | input | 16 | Descriptor base address for the activation |
| reg_we | input | 1 | Stop register write strobe |
| reg_wdata | input | 16 | Stop register write data |
| reg_rdata | output | 16 | Stop register contents |
| busy | output | 1 | Engine is serving an activation |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 16 | Request word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Response / bus-cycle end |
| mem_rsp_rdata | input | 16 | Read data |

## Verification
A register write or standby pulse shows on `reg_rdata` one edge after it is sampled, and the bench reads it at the following falling edge. `busy` rises two edges after an activation is sampled: one edge latches it as pending and one starts the sequencer. The bench checks `busy` at exactly that falling edge. Memory contents and the recorded order of bus addresses are only compared after `busy` has fallen. The memory model answers each accepted request on the next edge and alternates `mem_req_ready`, so request holding is exercised. The stop test watches `busy` and the access trace over several cycles before it releases the stop bit.

// File: rtl/dx_pkg.sv
package dx_pkg;
    localparam int W          = 16;
    localparam int DESC_WORDS = 4;
    localparam int CB_SRC_INC = 0;
    localparam int CB_DST_INC = 1;
    localparam int CB_CHAIN   = 2;
    localparam int CB_ON_ZERO = 3;
    localparam int CTL_BITS   = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_CTL, ST_RD_SRC, ST_RD_DST, ST_RD_CNT,
        ST_RD_DATA, ST_WR_DATA, ST_WB_SRC, ST_WB_DST, ST_WB_CNT
    } dx_state_e;

    typedef struct packed {
        dx_state_e           st;
        logic                wait_rsp;
        logic [W-1:0]        base;
        logic [CTL_BITS-1:0] ctl;
        logic [W-1:0]        src;
        logic [W-1:0]        dst;
        logic [W-1:0]        cnt;
        logic [W-1:0]        data;
    } dx_seq_s;
endpackage

// File: rtl/dx_mstop.sv
module dx_mstop #(
    parameter int          RW    = 16,
    parameter logic [15:0] RST   = 16'h3FFF,
    parameter int          SBIT  = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_hw,
    input  logic          busy,
    input  logic          we,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] rdata,
    output logic          stop
);
    localparam logic [RW-1:0] INIT = RW'(RST);

    logic [RW-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (stby_hw) begin
            val_d = INIT;
        end else if (we) begin
            val_d = wdata;
            if (busy) val_d[SBIT] = val_q[SBIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= INIT;
        else        val_q <= val_d;
    end

    assign rdata = val_q;
    assign stop  = val_q[SBIT];
endmodule

// File: rtl/dx_act_latch.sv
module dx_act_latch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_req,
    input  logic [AW-1:0] act_base,
    input  logic          accept,
    output logic          pend,
    output logic [AW-1:0] pend_base
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] base;
    } act_s;

    act_s d, q;

    always_comb begin
        d = q;
        if (accept) d.pend = 1'b0;
        if (act_req && (!q.pend || accept)) begin
            d.pend = 1'b1;
            d.base = act_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend      = q.pend;
    assign pend_base = q.base;
endmodule

// File: rtl/dx_seq.sv
module dx_seq
    import dx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] start_base,
    output logic         accept,
    output logic         busy,
    output logic         req_valid,
    input  logic         req_ready,
    output logic         req_we,
    output logic [W-1:0] req_addr,
    output logic [W-1:0] req_wdata,
    input  logic         rsp_valid,
    input  logic [W-1:0] rsp_rdata
);
    dx_seq_s d, q;

    // bus request fields per state
    always_comb begin
        req_we    = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        unique case (q.st)
            ST_RD_CTL:  req_addr = q.base;
            ST_RD_SRC:  req_addr = q.base + W'(1);
            ST_RD_DST:  req_addr = q.base + W'(2);
            ST_RD_CNT:  req_addr = q.base + W'(3);
            ST_RD_DATA: req_addr = q.src;
            ST_WR_DATA: begin req_we = 1'b1; req_addr = q.dst;          req_wdata = q.data; end
            ST_WB_SRC:  begin req_we = 1'b1; req_addr = q.base + W'(1); req_wdata = q.src;  end
            ST_WB_DST:  begin req_we = 1'b1; req_addr = q.base + W'(2); req_wdata = q.dst;  end
            ST_WB_CNT:  begin req_we = 1'b1; req_addr = q.base + W'(3); req_wdata = q.cnt;  end
            default: ;
        endcase
    end

    always_comb begin
        d         = q;
        accept    = 1'b0;
        req_valid = 1'b0;
        if (q.st == ST_IDLE) begin
            if (start) begin
                accept     = 1'b1;
                d.st       = ST_RD_CTL;
                d.base     = start_base;
                d.wait_rsp = 1'b0;
            end
        end else if (!q.wait_rsp) begin
            req_valid = 1'b1;
            if (req_ready) d.wait_rsp = 1'b1;
        end else if (rsp_valid) begin
            d.wait_rsp = 1'b0;
            unique case (q.st)
                ST_RD_CTL:  begin d.ctl  = rsp_rdata[CTL_BITS-1:0]; d.st = ST_RD_SRC; end
                ST_RD_SRC:  begin d.src  = rsp_rdata; d.st = ST_RD_DST;  end
                ST_RD_DST:  begin d.dst  = rsp_rdata; d.st = ST_RD_CNT;  end
                ST_RD_CNT:  begin d.cnt  = rsp_rdata; d.st = ST_RD_DATA; end
                ST_RD_DATA: begin d.data = rsp_rdata; d.st = ST_WR_DATA; end
                ST_WR_DATA: begin
                    if (q.ctl[CB_SRC_INC]) d.src = q.src + W'(1);
                    if (q.ctl[CB_DST_INC]) d.dst = q.dst + W'(1);
                    d.cnt = q.cnt - W'(1);
                    d.st  = ST_WB_SRC;
                end
                ST_WB_SRC:  d.st = ST_WB_DST;
                ST_WB_DST:  d.st = ST_WB_CNT;
                ST_WB_CNT: begin
                    if (q.ctl[CB_CHAIN] && (!q.ctl[CB_ON_ZERO] || q.cnt == '0)) begin
                        d.base = q.base + W'(DESC_WORDS);
                        d.st   = ST_RD_CTL;
                    end else begin
                        d.st   = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);
endmodule

// File: rtl/dxfer_engine.sv
module dxfer_engine
    import dx_pkg::*;
#(
    parameter int          STOP_W   = 16,
    parameter logic [15:0] STOP_RST = 16'h3FFF,
    parameter int          STOP_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stby_hw,
    input  logic              act_req,
    input  logic [W-1:0]      act_base,
    input  logic              reg_we,
    input  logic [STOP_W-1:0] reg_wdata,
    output logic [STOP_W-1:0] reg_rdata,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [W-1:0]      mem_req_addr,
    output logic [W-1:0]      mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [W-1:0]      mem_rsp_rdata
);
    logic         stop, pend, accept;
    logic [W-1:0] pend_base;

    dx_mstop #(.RW(STOP_W), .RST(STOP_RST), .SBIT(STOP_BIT)) u_mstop (
        .clk(clk), .rst_n(rst_n), .stby_hw(stby_hw), .busy(busy),
        .we(reg_we), .wdata(reg_wdata), .rdata(reg_rdata), .stop(stop)
    );

    dx_act_latch #(.AW(W)) u_act (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_base(act_base),
        .accept(accept), .pend(pend), .pend_base(pend_base)
    );

    dx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(pend && !stop), .start_base(pend_base),
        .accept(accept), .busy(busy),
        .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_we(mem_req_we),
        .req_addr(mem_req_addr), .req_wdata(mem_req_wdata),
        .rsp_valid(mem_rsp_valid), .rsp_rdata(mem_rsp_rdata)
    );
endmodule

// File: rtl/dxfer_engine_chk.sv
module dxfer_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stby_hw,
    input logic        reg_we,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        busy,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_we,
    input logic [15:0] mem_req_addr,
    input logic        mem_rsp_valid
);
    logic outst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              outst_q <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
        else if (mem_rsp_valid)                  outst_q <= 1'b0;
    end

    AST_STBY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stby_hw |=> (reg_rdata == 16'h3FFF)); // R2
    AST_BUSY_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reg_rdata[14] && reg_we && !stby_hw) |=> !reg_rdata[14]); // R3
    AST_STOP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[14] && !busy) |=> !busy); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we))); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !mem_req_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R10
endmodule

bind dxfer_engine dxfer_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stby_hw(stby_hw), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/tb_dxfer_engine.sv
module tb_dxfer_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby_hw = 1'b0;
    logic        act_req = 1'b0;
    logic [15:0] act_base = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        busy, mem_req_valid, mem_req_we;
    logic        mem_req_ready;
    logic [15:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_rdata = '0;

    always #10 clk = ~clk; // 50 MHz

    dxfer_engine dut (
        .clk(clk), .rst_n(rst_n), .stby_hw(stby_hw), .act_req(act_req), .act_base(act_base),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    int          total = 0, bad = 0, cyc = 0;
    logic [15:0] mem [256];
    logic [15:0] trace [64];
    int          tcnt = 0;
    logic        bd_we = 1'b0, bd_clr = 1'b0;
    logic [7:0]  bd_a = '0;
    logic [15:0] bd_d = '0;

    assign mem_req_ready = cyc[0];

    // memory model, backdoor pokes and access trace in one process
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (bd_we) mem[bd_a] <= bd_d;
        if (bd_clr) tcnt <= 0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) mem[mem_req_addr[7:0]] <= mem_req_wdata;
            else            mem_rsp_rdata <= mem[mem_req_addr[7:0]];
            mem_rsp_valid <= 1'b1;
            if (tcnt < 64) trace[tcnt] <= mem_req_addr;
            tcnt <= tcnt + 1;
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: run hung (actual cycle %0d, expected < 100000)", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] dv);
        @(negedge clk); bd_we = 1'b1; bd_a = a[7:0]; bd_d = dv;
        @(negedge clk); bd_we = 1'b0;
    endtask

    task automatic clr_trace();
        @(negedge clk); bd_clr = 1'b1;
        @(negedge clk); bd_clr = 1'b0;
    endtask

    task automatic put_desc(input logic [15:0] b, c, s, dd, n);
        poke(b, c); poke(b + 16'd1, s); poke(b + 16'd2, dd); poke(b + 16'd3, n);
    endtask

    // drive the pulse; returns at the falling edge after the pending edge
    task automatic activate(input logic [15:0] b);
        @(negedge clk); act_req = 1'b1; act_base = b;
        @(negedge clk); act_req = 1'b0;
    endtask

    task automatic wait_done();
        while (!busy) @(negedge clk);
        while (busy)  @(negedge clk);
    endtask

    task automatic wr_reg(input logic [15:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    // base, ctl, src, dst, cnt, data
    localparam logic [95:0] VEC [5] = '{
        {16'h0010, 16'h0000, 16'h0020, 16'h0030, 16'h0005, 16'hA5A5},
        {16'h0018, 16'h0001, 16'h0021, 16'h0031, 16'h0001, 16'h1234},
        {16'h0008, 16'h0002, 16'h0024, 16'h0034, 16'h0000, 16'hBEEF},
        {16'h000C, 16'h0003, 16'h0026, 16'h0036, 16'h0100, 16'h0F0F},
        {16'h0014, 16'h0003, 16'h00FF, 16'h00FE, 16'h0002, 16'h7777}
    };

    initial begin
        repeat (3) @(negedge clk);
        check(reg_rdata == 16'h3FFF, "R1 reset stop reg", reg_rdata, 16'h3FFF);
        check(!busy, "R1 reset busy", busy, 0);
        check(!mem_req_valid, "R1 reset req", mem_req_valid, 0);
        rst_n = 1'b1;
        wr_reg(16'h0000);

        // table walk: single descriptors, flag variants
        for (int i = 0; i < 5; i++) begin
            logic [15:0] b, c, s, dd, n, dv, es, ed;
            logic [15:0] exp_tr [9];
            bit tr_ok;
            {b, c, s, dd, n, dv} = VEC[i];
            put_desc(b, c, s, dd, n);
            poke(s, dv);
            poke(dd, 16'h0000);
            clr_trace();
            activate(b);
            check(!busy, "R10 busy low after pending edge", busy, 0);
            @(negedge clk);
            check(busy, "R10 busy high two edges after request", busy, 1);
            wait_done();
            es = c[0] ? s + 16'd1 : s;
            ed = c[1] ? dd + 16'd1 : dd;
            check(mem[dd[7:0]] == dv, "R5 moved word", mem[dd[7:0]], dv);
            check(mem[b[7:0] + 8'd1] == es, "R6 source writeback", mem[b[7:0] + 8'd1], es);
            check(mem[b[7:0] + 8'd2] == ed, "R6 destination writeback", mem[b[7:0] + 8'd2], ed);
            check(mem[b[7:0] + 8'd3] == n - 16'd1, "R6 count writeback", mem[b[7:0] + 8'd3], n - 16'd1);
            exp_tr = '{b, b + 16'd1, b + 16'd2, b + 16'd3, s, dd, b + 16'd1, b + 16'd2, b + 16'd3};
            tr_ok = (tcnt == 9);
            for (int k = 0; k < 9; k++) if (trace[k] != exp_tr[k]) tr_ok = 0;
            check(tr_ok, "R5 bus cycle order", tcnt, 9);
        end

        // R7: unconditional chain
        put_desc(16'h0040, 16'h0005, 16'h0080, 16'h0090, 16'h0003);
        put_desc(16'h0044, 16'h0000, 16'h0081, 16'h0091, 16'h0007);
        poke(16'h0080, 16'h1111); poke(16'h0081, 16'h2222);
        clr_trace();
        activate(16'h0040);
        wait_done();
        check(mem[8'h90] == 16'h1111, "R7 first move", mem[8'h90], 16'h1111);
        check(mem[8'h91] == 16'h2222, "R7 chained move", mem[8'h91], 16'h2222);
        check(mem[8'h47] == 16'h0006, "R7 chained count", mem[8'h47], 16'h0006);
        check(tcnt == 18, "R7 two descriptors in one activation", tcnt, 18);

        // R8: chain on zero, taken
        put_desc(16'h0050, 16'h000C, 16'h0082, 16'h0092, 16'h0001);
        put_desc(16'h0054, 16'h0000, 16'h0083, 16'h0093, 16'h0002);
        activate(16'h0050);
        wait_done();
        check(mem[8'h57] == 16'h0001, "R8 chain taken at zero", mem[8'h57], 16'h0001);
        // R8: chain on zero, not taken
        put_desc(16'h0060, 16'h000C, 16'h0084, 16'h0094, 16'h0005);
        put_desc(16'h0064, 16'h0000, 16'h0085, 16'h0095, 16'h0009);
        clr_trace();
        activate(16'h0060);
        wait_done();
        check(mem[8'h67] == 16'h0009, "R8 chain skipped on nonzero", mem[8'h67], 16'h0009);
        check(tcnt == 9, "R8 single descriptor traffic", tcnt, 9);

        // R3 idle write, R4 stop gating
        wr_reg(16'h4000);
        check(reg_rdata == 16'h4000, "R3 idle write", reg_rdata, 16'h4000);
        poke(16'h0020, 16'h5A5A); poke(16'h0030, 16'h0000);
        put_desc(16'h0010, 16'h0000, 16'h0020, 16'h0030, 16'h0005);
        clr_trace();
        activate(16'h0010);
        repeat (8) @(negedge clk);
        check(!busy, "R4 busy low while stopped", busy, 0);
        check(tcnt == 0, "R4 no bus traffic while stopped", tcnt, 0);
        wr_reg(16'h0000);
        @(negedge clk);
        check(busy, "R4 pending request served after release", busy, 1);
        wait_done();
        check(mem[8'h30] == 16'h5A5A, "R4 served move", mem[8'h30], 16'h5A5A);

        // R3: write of 1 to bit 14 while busy
        activate(16'h0010);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = 16'h4003;
        @(negedge clk); reg_we = 1'b0;
        check(reg_rdata == 16'h0003, "R3 bit 14 held while busy", reg_rdata, 16'h0003);
        wait_done();

        // R2: hardware standby reload
        wr_reg(16'h1234);
        @(negedge clk); stby_hw = 1'b1; reg_we = 1'b1; reg_wdata = 16'h0000;
        @(negedge clk); stby_hw = 1'b0; reg_we = 1'b0;
        check(reg_rdata == 16'h3FFF, "R2 standby reload", reg_rdata, 16'h3FFF);

        summary();
        $finish;
    end
endmodule